// File: doc/BRIEF.md
# Watchdog with Safe Frequency-Select Fallback

This block guards the control logic of a clock generator. Host software programs an 8-bit timeout multiplier, an enable bit and a 5-bit safe frequency-select code through a small register port. Once enabled, the watchdog counts coarse ticks. Each tick is one base period, nominally 293 ms, and comes from a prescaler on the system clock. If neither a kick pulse nor a write to the multiplier reloads the count before it runs out, the block enters alarm mode. It latches a status flag, emits a one-cycle reset request, and replaces the normal frequency-select code with the stored safe code.

The multiplier resets to 16, so the default timeout is about 4.688 s. For simulation, the tick length is a parameter counted in system clock cycles. In the clock generator, the frequency-select output feeds the PLL configuration and the reset request drives the system reset logic.

Top module: `wdog_safe_fsel`

## Requirements
- R1: After reset the multiplier reads 16, the control register reads 0 (disabled, no alarm, safe code 0), the reset request is low, and the frequency-select output equals the frequency-select input.
- R2: Register address 0 holds the 8-bit multiplier. Address 1 holds the control fields: bit 7 is enable, bit 6 is alarm status, bits 4:0 are the safe code, and bit 5 always reads 0. Addresses 2 and 3 read 0. Read data is combinational on the read address.
- R3: While enabled, an expiry occurs on the rising edge that falls multiplier × TICK_CYCLES edges after the edge that last reloaded the count. A multiplier of 0 behaves as 1.
- R4: Each expiry raises the reset request for exactly one cycle, in the cycle after the expiry edge. The count then reloads, so an unserviced watchdog expires again after another full timeout.
- R5: An expiry sets the alarm status. Writing 0 to status bit 6 clears it. Writing 1 to bit 6 has no effect. If a clear and an expiry fall on the same edge, the expiry wins.
- R6: While the block is enabled and the alarm status is set, the frequency-select output equals the safe code. Otherwise it equals the frequency-select input.
- R7: A kick pulse reloads the count and restarts the prescaler. A kick on the edge where an expiry would occur prevents that expiry.
- R8: Any write to the multiplier reloads the count with the newly written value, with the same timing as a kick.
- R9: While disabled, the count holds the multiplier value, no expiry or reset request occurs, and the frequency-select input passes through even if the status is set. Enabling starts a full timeout from the enabling write.
- R10: The alarm status can only become set while the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick_i | input | 1 | Service pulse that reloads the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data |
| fsel_i | input | 5 | Normal frequency-select code |
| fsel_o | output | 5 | Frequency-select code applied to the generator |
| rst_req_o | output | 1 | One-cycle system reset request |
| alarm_o | output | 1 | Alarm status flag |

## Verification
The embedded properties check several rules on every clock:
- While disabled, the count tracks the reload value.
- Each tick steps the count down by exactly one.
- The prescaler returns to zero after a tick.
- A reset request always coincides with the alarm status and, with ticks longer than one cycle, never lasts two cycles.
- The status rises only while enabled, and a host clear takes effect unless an expiry coincides.

The exact expiry cycle for a given multiplier requires the bench's scenarios. So do the repeat interval when the watchdog is unserviced, the kick that lands on the expiry edge, and the reload on a multiplier write. The bench also covers the zero multiplier, the safe-code substitution and its release, and pass-through while disabled with the status still set.

// File: rtl/wdog_pkg.sv
// Shared constants and register selector for the watchdog block.
package wdog_pkg;
    localparam int MULT_W      = 8;
    localparam int FSEL_W      = 5;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 2;
    localparam int CTRL_EN_BIT = 7;
    localparam int CTRL_ST_BIT = 6;
    localparam logic [MULT_W-1:0] MULT_RST = MULT_W'(16);

    typedef enum logic [ADDR_W-1:0] {
        REG_MULT = 2'd0,
        REG_CTRL = 2'd1,
        REG_RSV2 = 2'd2,
        REG_RSV3 = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/wdog_prescaler.sv
// Coarse tick generator: divides the system clock by TICK_CYCLES.
// Assumes: restart_i or !run_i returns the phase to zero; tick_o is
// suppressed in a restart cycle so a reload always wins over a tick.
module wdog_prescaler #(
    parameter int TICK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

    logic [PRE_W-1:0] pre_q;

    // Tick fires on the last phase of a running, non-restarting period.
    assign tick_o = run_i && !restart_i && (pre_q == PRE_LAST);

    // Phase counter: clears on reset, stop or restart; wraps at the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || restart_i) begin
            pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    assert_phase_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (pre_q == '0))
        else $error("prescaler did not wrap after a tick");
endmodule

// File: rtl/wdog_downcount.sv
// Timeout down-counter and reset-request pulse.
// Assumes: reload_val_i already carries a multiplier value written in the
// same cycle, so a reload always takes the newest value.
module wdog_downcount import wdog_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              reload_i,
    input  logic              tick_i,
    input  logic [MULT_W-1:0] reload_val_i,
    output logic              expire_o,
    output logic              rst_req_o
);
    logic [MULT_W-1:0] cnt_q;
    logic              last_tick;

    // A count of 0 or 1 is on its final tick (0 behaves as 1).
    assign last_tick = (cnt_q <= MULT_W'(1));
    assign expire_o  = run_i && !reload_i && tick_i && last_tick;

    // Count register: holds reload value when stopped, steps down per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= MULT_RST;
        end else if (!run_i || reload_i) begin
            cnt_q <= reload_val_i;
        end else if (tick_i) begin
            cnt_q <= last_tick ? reload_val_i : (cnt_q - MULT_W'(1));
        end
    end

    // Reset request: one cycle after each expiry edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_o <= 1'b0;
        end else begin
            rst_req_o <= expire_o;
        end
    end

    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == $past(reload_val_i)))
        else $error("count moved while disabled");

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !reload_i && tick_i && (cnt_q > MULT_W'(1))) |=> (cnt_q == $past(cnt_q) - MULT_W'(1)))
        else $error("count did not step by one");
endmodule

// File: rtl/wdog_regs.sv
// Host register file: multiplier, enable, alarm status and safe code.
// Assumes: one write per cycle; status bit is set by expire_i and only
// cleared by writing 0 to it, with expiry taking priority.
module wdog_regs import wdog_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              expire_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              mult_wr_o,
    output logic [MULT_W-1:0] load_val_o,
    output logic              en_o,
    output logic              alarm_o,
    output logic [FSEL_W-1:0] safe_o
);
    logic [MULT_W-1:0] mult_q;
    logic              en_q;
    logic              stat_q;
    logic [FSEL_W-1:0] safe_q;
    logic              ctrl_wr;
    logic              rsv_bit_unused;

    assign mult_wr_o      = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_MULT);
    assign ctrl_wr        = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_CTRL);
    assign rsv_bit_unused = wr_data_i[5];

    // Reload value: bypass a multiplier being written this cycle.
    assign load_val_o = mult_wr_o ? wr_data_i[MULT_W-1:0] : mult_q;
    assign en_o       = en_q;
    assign alarm_o    = stat_q;
    assign safe_o     = safe_q;

    // Multiplier register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q <= MULT_RST;
        end else if (mult_wr_o) begin
            mult_q <= wr_data_i[MULT_W-1:0];
        end
    end

    // Enable and safe-code fields of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            safe_q <= '0;
        end else if (ctrl_wr) begin
            en_q   <= wr_data_i[CTRL_EN_BIT];
            safe_q <= wr_data_i[FSEL_W-1:0];
        end
    end

    // Alarm status: set by expiry, cleared by writing zero, expiry wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (expire_i) begin
            stat_q <= 1'b1;
        end else if (ctrl_wr && !wr_data_i[CTRL_ST_BIT]) begin
            stat_q <= 1'b0;
        end
    end

    // Read mux over the register map.
    always_comb begin
        rd_data_o = '0;
        case (reg_sel_e'(rd_addr_i))
            REG_MULT: rd_data_o = DATA_W'(mult_q);
            REG_CTRL: begin
                rd_data_o[CTRL_EN_BIT]  = en_q;
                rd_data_o[CTRL_ST_BIT]  = stat_q;
                rd_data_o[FSEL_W-1:0]   = safe_q;
            end
            default:  rd_data_o = '0;
        endcase
    end

    assert_host_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data_i[CTRL_ST_BIT] && !expire_i) |=> !stat_q)
        else $error("status clear ignored");
endmodule

// File: rtl/wdog_safe_fsel.sv
// Watchdog with safe frequency-select fallback (top level).
// Assumes: TICK_CYCLES is the base period in system clock cycles; kick_i
// and register writes are synchronous single-cycle strobes.
module wdog_safe_fsel import wdog_pkg::*; #(
    parameter int TICK_CYCLES = 36_625_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [FSEL_W-1:0] fsel_i,
    output logic [FSEL_W-1:0] fsel_o,
    output logic              rst_req_o,
    output logic              alarm_o
);
    logic              mult_wr;
    logic [MULT_W-1:0] load_val;
    logic              en;
    logic [FSEL_W-1:0] safe_code;
    logic              reload;
    logic              tick;
    logic              expire;

    assign reload = kick_i || mult_wr;

    wdog_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .expire_i   (expire),
        .rd_data_o  (rd_data_o),
        .mult_wr_o  (mult_wr),
        .load_val_o (load_val),
        .en_o       (en),
        .alarm_o    (alarm_o),
        .safe_o     (safe_code)
    );

    wdog_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (en),
        .restart_i (reload),
        .tick_o    (tick)
    );

    wdog_downcount u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (en),
        .reload_i     (reload),
        .tick_i       (tick),
        .reload_val_i (load_val),
        .expire_o     (expire),
        .rst_req_o    (rst_req_o)
    );

    // Output select: safe code only while enabled and in alarm.
    assign fsel_o = (en && alarm_o) ? safe_code : fsel_i;

    assert_req_with_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> alarm_o)
        else $error("reset request without alarm status");

    assert_alarm_only_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> $past(en))
        else $error("alarm set while disabled");

    generate
        if (TICK_CYCLES > 1) begin : g_pulse_chk
            assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
                rst_req_o |=> !rst_req_o)
                else $error("reset request wider than one cycle");
        end
    endgenerate
endmodule

// File: tb/test_wdog_safe_fsel.sv
module test_wdog_safe_fsel;
    localparam int T = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       kick;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic [4:0] fsel_in;
    logic [4:0] fsel_out;
    logic       rst_req;
    logic       alarm;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  finished = 0;
    logic prev_req = 1'b0;

    typedef struct {
        int    cyc;
        string req;
    } pulse_t;
    pulse_t sb_q[$];

    wdog_safe_fsel #(.TICK_CYCLES(T)) i_wdog_safe_fsel (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .fsel_i(fsel_in), .fsel_o(fsel_out),
        .rst_req_o(rst_req), .alarm_o(alarm)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Scoreboard monitor: every reset-request pulse must match the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
                chk(1'b0, {sb_q[0].req, " missed pulse"}, cyc, sb_q[0].cyc);
                void'(sb_q.pop_front());
            end
            if (rst_req) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected reset request", cyc, 0);
                end else begin
                    pulse_t it;
                    it = sb_q.pop_front();
                    chk(cyc == it.cyc, it.req, cyc, it.cyc);
                end
                if (prev_req) chk(1'b0, "R4 pulse wider than one cycle", 2, 1);
            end
            prev_req = rst_req;
        end
    end

    // Driver tasks: all are entered at a negedge.
    task automatic push_pulse(input int c, input string req);
        pulse_t it;
        it.cyc = c;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d, output int edge_n);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        edge_n = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_kick(output int edge_n);
        kick = 1'b1;
        edge_n = cyc + 1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(rd_data == exp, req, rd_data, exp);
    endtask

    initial begin
        int L, K, X, W, W2, E, dummy;
        rst_n = 1'b0; kick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; fsel_in = 5'h0A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_chk(2'd0, 8'd16, "R1 multiplier reset");
        read_chk(2'd1, 8'h00, "R1 control reset");
        chk(rst_req == 1'b0, "R1 reset request low", rst_req, 0);
        chk(alarm == 1'b0, "R1 alarm low", alarm, 0);
        chk(fsel_out == fsel_in, "R1 fsel pass-through", fsel_out, fsel_in);

        // R2: register map, reserved bit, status write of 1 ignored (R5)
        do_write(2'd0, 8'd3, dummy);
        read_chk(2'd0, 8'd3, "R2 multiplier readback");
        do_write(2'd1, 8'h75, dummy);
        read_chk(2'd1, 8'h15, "R2 R5 control readback");
        read_chk(2'd2, 8'h00, "R2 reserved address");

        // R9/R10: disabled, no alarm ever
        repeat (60) @(negedge clk);
        chk(alarm == 1'b0, "R9 R10 no alarm while disabled", alarm, 0);

        // R3/R4: enable, two unserviced expiries
        do_write(2'd1, 8'h95, L);
        push_pulse(L + 3*T, "R3 first expiry");
        push_pulse(L + 6*T, "R4 repeated expiry");
        wait_to(L + 3*T + 1);
        chk(alarm == 1'b1, "R5 alarm set on expiry", alarm, 1);
        chk(fsel_out == 5'h15, "R6 safe code applied", fsel_out, 5'h15);
        read_chk(2'd1, 8'hD5, "R5 status readback");
        wait_to(L + 6*T + 2);

        // R7: periodic kicks keep it quiet
        do_kick(K);
        repeat (6) begin
            repeat (8) @(negedge clk);
            do_kick(K);
        end
        // R7: kick on the expiry edge
        X = K + 3*T;
        wait_to(X - 1);
        do_kick(K);
        chk(K == X, "R7 kick aligned", K, X);
        push_pulse(X + 3*T, "R7 expiry after aligned kick");
        @(negedge clk);

        // R5: host clear while enabled
        do_write(2'd1, 8'h95, dummy);
        read_chk(2'd1, 8'h95, "R5 status cleared");
        chk(alarm == 1'b0, "R5 alarm cleared", alarm, 0);
        chk(fsel_out == 5'h0A, "R6 normal code after clear", fsel_out, 5'h0A);
        wait_to(X + 3*T + 1);
        chk(alarm == 1'b1, "R5 alarm set again", alarm, 1);

        // R8: multiplier write reloads with the new value
        do_write(2'd0, 8'd2, W);
        push_pulse(W + 2*T, "R8 reload on multiplier write");
        wait_to(W + 2*T + 1);
        // R3: multiplier 0 behaves as 1
        do_write(2'd0, 8'd0, W2);
        push_pulse(W2 + T, "R3 zero multiplier first");
        push_pulse(W2 + 2*T, "R3 zero multiplier second");
        wait_to(W2 + 2*T + 1);

        // R9: disable with status kept
        do_write(2'd1, 8'h55, dummy);
        chk(alarm == 1'b1, "R9 status kept while disabled", alarm, 1);
        chk(fsel_out == 5'h0A, "R9 pass-through while disabled", fsel_out, 5'h0A);
        fsel_in = 5'h03;
        #1;
        chk(fsel_out == 5'h03, "R9 pass-through follows input", fsel_out, 5'h03);
        read_chk(2'd1, 8'h55, "R9 control readback");
        read_chk(2'd0, 8'h00, "R8 multiplier zero readback");
        repeat (50) @(negedge clk);

        // R9: enabling starts a full timeout
        do_write(2'd0, 8'd2, dummy);
        do_write(2'd1, 8'hD5, E);
        push_pulse(E + 2*T, "R9 full timeout after enable");
        wait_to(E + 2*T + 1);
        chk(fsel_out == 5'h15, "R6 safe code after re-enable", fsel_out, 5'h15);
        do_write(2'd1, 8'h15, dummy);
        chk(alarm == 1'b0, "R5 final clear", alarm, 0);
        chk(fsel_out == 5'h03, "R6 normal code restored", fsel_out, 5'h03);
        repeat (30) @(negedge clk);
        chk(sb_q.size() == 0, "R4 all expected pulses seen", sb_q.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule